// File: doc/BRIEF.md
# Programmable AND-OR Logic Array with Registered Macrocells

This block is a small field-configurable two-level logic array. A product-term plane ANDs together a chosen set of literals, and a sum plane ORs chosen product terms into each output. The literals come from the logic inputs and from fed-back macrocell state, each taken in true or complemented form. Both planes are programmable from a personality vector. Each output passes through a macrocell. The macrocell can present the sum directly or the value a D flip-flop captured from it, and it can hold the pin off. Because the macrocell state returns to the product plane, small state machines such as counters and sequence detectors can be built inside the array.

The personality is loaded serially. A host raises the load strobe and shifts the whole vector in, most significant bit first, one bit per clock. The array keeps running on the previous personality during the shift. The new personality takes over on the clock edge after the strobe falls. At power-up every connection is unprogrammed, so every output reads 0 until a personality is loaded.

Top module: `pla_array`

## Requirements
- R1: After power-up and reset, with no personality loaded, every `dout` bit and every `dout_oe` bit is 0 for any input pattern.
- R2: Product term p takes variable v from the 2-bit field at personality bits [2*(p*N_VAR+v) +: 2]. The codes are: 00 leaves the variable out (it counts as 1), 01 uses it true, 10 uses it complemented, and 11 forces the product to 0. Variables 0..N_IN-1 are `din` bits.
- R3: Personality bit AND_W + o*N_PT + p set to 1 connects product p to output o's OR gate. A product whose bit is 0 never makes that sum 1. AND_W = 2*N_VAR*N_PT.
- R4: When output o's select bit (personality bit MC_OFF + 2*o) is 0, the output shows the current sum in the same cycle as the input change.
- R5: Each macrocell flip-flop captures its sum on every rising clock edge. When the select bit is 1, the output shows the flip-flop value, so it changes one edge after the sum.
- R6: Output o's enable bit (personality bit MC_OFF + 2*o + 1) drives `dout_oe[o]`. While the enable is 0, `dout[o]` is 0.
- R7: Product-plane variable N_IN+k is the flip-flop of macrocell k, in whichever select mode. This lets registered outputs form a state machine.
- R8: While `cfg_load` is high, `cfg_data` is shifted in MSB first and the active personality does not change. The shifted vector becomes active at the first rising edge at which `cfg_load` is low after having been high.
- R9: A synchronous `rst` clears all macrocell flip-flops to 0. It leaves the active personality unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of macrocell state |
| din | input | N_IN | Logic inputs to the product plane |
| cfg_load | input | 1 | High while personality bits are being shifted in |
| cfg_data | input | 1 | Serial personality bit, MSB first |
| dout | output | N_OUT | Macrocell outputs, 0 when disabled |
| dout_oe | output | N_OUT | Per-output drive-enable flag |

## Verification
The first directed personality is purely combinational and is driven through all eight input codes. This separates true from complemented literals and shows which product terms reach which sums. A second personality mixes registered and combinational outputs, disables one output and puts a forcing literal in one term. Driving it with random inputs shows the one-edge lag of a registered output against the immediate sum, and shows the disabled output held off. A two-bit counter built from feedback tests the state path. It is checked against a cycle count from reset, including a reset part-way through and a personality reload shifted in while the counter keeps running. Randomly drawn personalities with random inputs then cover mixes of all of these.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    LIT_NONE = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_KILL = 2'b11
  } lit_e;

  typedef struct packed {
    logic en;
    logic sel;
  } mc_cfg_t;

  function automatic logic lit_pass(input lit_e code, input logic val);
    case (code)
      LIT_NONE: return 1'b1;
      LIT_TRUE: return val;
      LIT_COMP: return ~val;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pla_cfg_shift.sv
module pla_cfg_shift #(
  parameter int W = 98
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_load,
  input  logic         cfg_data,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         load_q
);

  logic [W-1:0] shadow_q = '0;
  logic [W-1:0] active_q = '0;
  logic         load_r   = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) load_r <= 1'b0;
    else     load_r <= cfg_load;
  end

  always_ff @(posedge clk) begin
    if (cfg_load) shadow_q <= {shadow_q[W-2:0], cfg_data};
  end

  always_ff @(posedge clk) begin
    if (!rst && load_r && !cfg_load) active_q <= shadow_q;
  end

  assign shadow = shadow_q;
  assign active = active_q;
  assign load_q = load_r;

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_VAR = 7,
  parameter int N_PT  = 5,
  localparam int CW   = 2 * N_VAR * N_PT
) (
  input  logic [CW-1:0]    and_cfg,
  input  logic [N_VAR-1:0] vars,
  output logic [N_PT-1:0]  prod
);

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    logic [N_VAR-1:0] pass;
    for (genvar v = 0; v < N_VAR; v++) begin : g_var
      lit_e code;
      assign code    = lit_e'(and_cfg[2*(p*N_VAR+v) +: 2]);
      assign pass[v] = lit_pass(code, vars[v]);
    end
    assign prod[p] = &pass;
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_PT  = 5,
  parameter int N_OUT = 4,
  localparam int CW   = N_PT * N_OUT
) (
  input  logic [CW-1:0]    or_cfg,
  input  logic [N_PT-1:0]  prod,
  output logic [N_OUT-1:0] sum
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_PT-1:0] hit;
    assign hit    = prod & or_cfg[o*N_PT +: N_PT];
    assign sum[o] = |hit;
  end

endmodule

// File: rtl/pla_macrocell.sv
module pla_macrocell
  import pla_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sum,
  input  mc_cfg_t cfg,
  output logic    q,
  output logic    pin,
  output logic    oe
);

  logic q_r;

  always_ff @(posedge clk) begin
    if (rst) q_r <= 1'b0;
    else     q_r <= sum;
  end

  logic pick;
  assign pick = cfg.sel ? q_r : sum;
  assign pin  = cfg.en & pick;
  assign oe   = cfg.en;
  assign q    = q_r;

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int N_PT  = 5,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  din,
  input  logic             cfg_load,
  input  logic             cfg_data,
  output logic [N_OUT-1:0] dout,
  output logic [N_OUT-1:0] dout_oe
);

  localparam int N_VAR  = N_IN + N_OUT;
  localparam int AND_W  = 2 * N_VAR * N_PT;
  localparam int OR_W   = N_PT * N_OUT;
  localparam int MC_W   = 2 * N_OUT;
  localparam int OR_OFF = AND_W;
  localparam int MC_OFF = AND_W + OR_W;
  localparam int CFG_W  = AND_W + OR_W + MC_W;

  logic [CFG_W-1:0] cfg_shadow;
  logic [CFG_W-1:0] cfg_act;
  logic             load_q;
  logic [N_VAR-1:0] vars;
  logic [N_PT-1:0]  prod;
  logic [N_OUT-1:0] sum;
  logic [N_OUT-1:0] fb_q;

  pla_cfg_shift #(.W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .cfg_data (cfg_data),
    .shadow   (cfg_shadow),
    .active   (cfg_act),
    .load_q   (load_q)
  );

  assign vars = {fb_q, din};

  pla_and_plane #(.N_VAR(N_VAR), .N_PT(N_PT)) u_and (
    .and_cfg (cfg_act[0 +: AND_W]),
    .vars    (vars),
    .prod    (prod)
  );

  pla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .or_cfg (cfg_act[OR_OFF +: OR_W]),
    .prod   (prod),
    .sum    (sum)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_mc
    mc_cfg_t mcfg;
    assign mcfg = mc_cfg_t'(cfg_act[MC_OFF + 2*o +: 2]);
    pla_macrocell u_mc (
      .clk (clk),
      .rst (rst),
      .sum (sum[o]),
      .cfg (mcfg),
      .q   (fb_q[o]),
      .pin (dout[o]),
      .oe  (dout_oe[o])
    );
  end

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int N_IN  = 3,
  parameter int N_PT  = 5,
  parameter int N_OUT = 4,
  localparam int N_VAR = N_IN + N_OUT,
  localparam int AND_W = 2 * N_VAR * N_PT,
  localparam int CFG_W = AND_W + N_PT * N_OUT + 2 * N_OUT
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_load,
  input logic             load_q,
  input logic [CFG_W-1:0] shadow,
  input logic [CFG_W-1:0] act,
  input logic [N_PT-1:0]  prod,
  input logic [N_OUT-1:0] sum,
  input logic [N_OUT-1:0] fb_q
);

  AST_FF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> fb_q == $past(sum)) else $error("flop missed sum"); // R5

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> $stable(act)) else $error("personality moved during load"); // R8

  AST_CFG_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (load_q && !cfg_load) |=> act == $past(shadow)) else $error("commit lost"); // R8

  for (genvar p = 0; p < N_PT; p++) begin : g_kill
    logic kill;
    always_comb begin
      kill = 1'b0;
      for (int v = 0; v < N_VAR; v++)
        if (act[2*(p*N_VAR+v) +: 2] == 2'b11) kill = 1'b1;
    end
    AST_KILL_TERM: assert property (@(posedge clk) disable iff (rst)
      kill |-> !prod[p]) else $error("forced term active"); // R2
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_orz
    AST_OR_OPEN: assert property (@(posedge clk) disable iff (rst)
      (act[AND_W + o*N_PT +: N_PT] == '0) |-> !sum[o]) else $error("open sum high"); // R3
  end

endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_load (cfg_load),
  .load_q   (load_q),
  .shadow   (cfg_shadow),
  .act      (cfg_act),
  .prod     (prod),
  .sum      (sum),
  .fb_q     (fb_q)
);

// File: tb/pla_array_test.sv
`timescale 1ns/1ps
module pla_array_test;

  localparam int NI = 3, NP = 5, NO = 4;
  localparam int NV = NI + NO;
  localparam int AW = 2 * NV * NP;
  localparam int OW = NP * NO;
  localparam int MO = AW + OW;
  localparam int W  = AW + OW + 2 * NO;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NI-1:0] din = '0;
  logic cfg_load = 1'b0;
  logic cfg_data = 1'b0;
  logic [NO-1:0] dout, dout_oe;

  pla_array #(.N_IN(NI), .N_PT(NP), .N_OUT(NO)) uut (
    .clk(clk), .rst(rst), .din(din), .cfg_load(cfg_load),
    .cfg_data(cfg_data), .dout(dout), .dout_oe(dout_oe)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] act_m = '0, sh_m = '0;
  logic ldp_m = 1'b0;
  logic [NO-1:0] mq = '0;

  function automatic logic [NO-1:0] m_sum(logic [W-1:0] c, logic [NI-1:0] x, logic [NO-1:0] q);
    logic [NV-1:0] vv;
    logic [NP-1:0] pr;
    logic [NO-1:0] s;
    vv = {q, x};
    for (int p = 0; p < NP; p++) begin
      pr[p] = 1'b1;
      for (int v = 0; v < NV; v++) begin
        case (c[2*(p*NV+v) +: 2])
          2'b01: pr[p] = pr[p] & vv[v];
          2'b10: pr[p] = pr[p] & ~vv[v];
          2'b11: pr[p] = 1'b0;
          default: ;
        endcase
      end
    end
    for (int o = 0; o < NO; o++) s[o] = |(pr & c[AW + o*NP +: NP]);
    return s;
  endfunction

  function automatic logic [2*NO-1:0] m_out(logic [W-1:0] c, logic [NI-1:0] x, logic [NO-1:0] q);
    logic [NO-1:0] s, d, e;
    s = m_sum(c, x, q);
    for (int o = 0; o < NO; o++) begin
      e[o] = c[MO + 2*o + 1];
      d[o] = e[o] & (c[MO + 2*o] ? q[o] : s[o]);
    end
    return {d, e};
  endfunction

  function automatic logic [W-1:0] set_lit(logic [W-1:0] c, int p, int v, logic [1:0] code);
    c[2*(p*NV+v) +: 2] = code;
    return c;
  endfunction

  function automatic logic [W-1:0] set_or(logic [W-1:0] c, int o, int p);
    c[AW + o*NP + p] = 1'b1;
    return c;
  endfunction

  function automatic logic [W-1:0] set_mc(logic [W-1:0] c, int o, logic sel, logic en);
    c[MO + 2*o] = sel;
    c[MO + 2*o + 1] = en;
    return c;
  endfunction

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic [NI-1:0] x, input logic ld, input logic dat);
    din = x; cfg_load = ld; cfg_data = dat;
    #1;
    check_val(tag, {24'd0, dout, dout_oe}, {24'd0, m_out(act_m, x, mq)});
    @(posedge clk);
    if (rst) begin
      mq = '0; ldp_m = 1'b0;
    end else begin
      mq = m_sum(act_m, x, mq);
      if (ldp_m && !ld) act_m = sh_m;
      ldp_m = ld;
    end
    if (ld) sh_m = {sh_m[W-2:0], dat};
    @(negedge clk);
  endtask

  task automatic load(input logic [W-1:0] c, input string tag);
    for (int i = W - 1; i >= 0; i--) step(tag, 3'($urandom), 1'b1, c[i]);
    step(tag, 3'($urandom), 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] c;
    void'($urandom(32'd1234));
    @(negedge clk);
    rst = 1'b1;
    step("R1 reset", 3'd0, 1'b0, 1'b0);
    step("R1 reset", 3'd5, 1'b0, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      step("R1 unprogrammed", 3'(i), 1'b0, 1'b0);
      check_val("R1 dout zero", {28'd0, dout}, 32'd0);
    end

    // Personality A: combinational, all enabled. Vars 0..2 = A,B,C (din[0..2]).
    c = '0;
    c = set_lit(c, 0, 0, 2'b01); c = set_lit(c, 0, 1, 2'b01);
    c = set_lit(c, 1, 1, 2'b10); c = set_lit(c, 1, 2, 2'b01);
    c = set_lit(c, 2, 0, 2'b01); c = set_lit(c, 2, 2, 2'b10);
    c = set_lit(c, 3, 1, 2'b10); c = set_lit(c, 3, 2, 2'b10);
    c = set_lit(c, 4, 0, 2'b01);
    c = set_or(c, 0, 0); c = set_or(c, 0, 2);
    c = set_or(c, 1, 3); c = set_or(c, 1, 4);
    c = set_or(c, 2, 0); c = set_or(c, 2, 3);
    c = set_or(c, 3, 1); c = set_or(c, 3, 4);
    for (int o = 0; o < NO; o++) c = set_mc(c, o, 1'b0, 1'b1);
    load(c, "R8 hold during load");
    for (int i = 0; i < 8; i++) step("R2 R3 R4 exhaustive", 3'(i), 1'b0, 1'b0);
    // Directed: A=1,B=1,C=0 -> F0=1,F1=1,F2=1,F3=1
    din = 3'b011; #1;
    check_val("R4 directed ABnotC", {28'd0, dout}, 32'hF);
    // A=0,B=0,C=1 -> only P1 -> F3
    din = 3'b100; #1;
    check_val("R2 directed notB C", {28'd0, dout}, 32'h8);

    // Personality B: out0,out1 registered, out2 disabled, term 4 forced off.
    c = set_mc(c, 0, 1'b1, 1'b1);
    c = set_mc(c, 1, 1'b1, 1'b1);
    c = set_mc(c, 2, 1'b0, 1'b0);
    c = set_lit(c, 4, 5, 2'b11);
    load(c, "R8 reload");
    for (int i = 0; i < 24; i++) step("R5 R6 R2 mixed", 3'($urandom), 1'b0, 1'b0);
    din = 3'b001; #1;
    check_val("R6 disabled out", {31'd0, dout[2]}, 32'd0);
    check_val("R6 oe flags", {28'd0, dout_oe}, 32'hB);
    check_val("R2 forced term F3", {31'd0, dout[3]}, 32'd0);

    // Personality C: 2-bit counter in out0/out1 via feedback vars 3,4.
    c = '0;
    c = set_lit(c, 0, 3, 2'b10);
    c = set_lit(c, 1, 4, 2'b01); c = set_lit(c, 1, 3, 2'b10);
    c = set_lit(c, 2, 4, 2'b10); c = set_lit(c, 2, 3, 2'b01);
    c = set_or(c, 0, 0); c = set_or(c, 1, 1); c = set_or(c, 1, 2);
    c = set_mc(c, 0, 1'b1, 1'b1); c = set_mc(c, 1, 1'b1, 1'b1);
    load(c, "R8 counter load");
    rst = 1'b1;
    step("R9 reset", 3'd0, 1'b0, 1'b0);
    rst = 1'b0;
    for (int k = 0; k < 10; k++) begin
      check_val("R7 counter", {30'd0, dout[1:0]}, 32'(k % 4));
      step("R7 feedback", 3'($urandom), 1'b0, 1'b0);
    end
    rst = 1'b1;
    step("R9 mid reset", 3'd0, 1'b0, 1'b0);
    rst = 1'b0;
    for (int k = 0; k < 6; k++) begin
      check_val("R9 counter after reset", {30'd0, dout[1:0]}, 32'(k % 4));
      step("R9 personality kept", 3'($urandom), 1'b0, 1'b0);
    end

    // Random personalities.
    for (int r = 0; r < 6; r++) begin
      c = '0;
      for (int p = 0; p < NP; p++)
        for (int v = 0; v < NV; v++) begin
          int u;
          u = int'($urandom % 8);
          c = set_lit(c, p, v, (u < 3) ? 2'b00 : (u < 5) ? 2'b01 : (u < 7) ? 2'b10 : 2'b11);
        end
      for (int b = AW; b < W; b++) c[b] = 1'($urandom);
      load(c, "R8 random load");
      for (int i = 0; i < 30; i++) step("R2 R3 R5 R7 random", 3'($urandom), 1'b0, 1'b0);
    end
    finish_run();
  end

endmodule